// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Protection

This block is a two-wire serial slave placed in front of an on-chip byte memory of 1024 x 8 by default. The clock and data lines are sampled with the system clock. The block finds start and stop conditions on the sampled lines, shifts in device-address, word-address and data bytes, and acknowledges each byte by pulling the data line low. A master can set an address and then write one byte or a page of bytes. A master can also read at a random address, continue from the current address, or stream bytes one after another.

Written bytes are first staged in a page buffer. A stop condition hands them to a self-timed write cycle, whose length is a parameter. During that cycle the slave stays off the bus, so a master finds out when the write is done by polling with the device address. A write-protect input blocks the commit for a region that a parameter picks: the whole array or its upper half. The open-drain data output is a single pull-low enable.

Top module: `e2w_slave`

## Requirements
- R1: After reset the slave is in standby with the data line released, and no write cycle is running.
- R2: SDA falling while SCL is high is a start, and it restarts byte framing from any state. SDA rising while SCL is high is a stop, which releases the data line and returns the slave to standby.
- R3: A device-address byte whose upper four bits are 1010 is acknowledged by pulling SDA low during the ninth clock. Any other value gets no acknowledge, and every byte after it is ignored (no acknowledge) until the next start.
- R4: Bits 2:1 of the write device-address byte become word-address bits 9:8. The next byte supplies word-address bits 7:0. Bit 0 of the device byte is 1 for a read and 0 for a write.
- R5: Incoming bits are captured on the rising edge of SCL. The slave changes its SDA drive only after a falling edge of SCL, or on a start or stop, so its data bits stay stable while SCL is high.
- R6: A write of one or more bytes followed by a stop commits the staged bytes in a self-timed write cycle lasting exactly WRITE_CYCLES system clocks.
- R7: A page write stages up to PAGE_BYTES (16) bytes. Address bits 3:0 wrap inside the page while bits 9:4 stay fixed. A later byte for the same offset replaces the earlier one. A partial page write leaves the other bytes of the page unchanged.
- R8: While a write cycle runs, the device address is not acknowledged. After the cycle ends, it is acknowledged again.
- R9: With the write-protect input high, a write to the protected region (the whole array when PROT_FULL=1, the default; the upper half when PROT_FULL=0) leaves the memory unchanged and starts no write cycle. With it low, writes work normally.
- R10: A random read sets the word address in a write frame, follows it with a repeated start and a read device byte, and returns the byte stored at that address.
- R11: Reads advance the address after every byte and roll over from 0x3FF to 0x000. A master acknowledge asks for one more byte, and a master no-acknowledge ends the transfer. A later read without a word address continues at the next address.
- R12: Staged bytes reach the memory only through a write cycle started by a stop. A repeated start before the stop discards them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired bus value) |
| wpIn | input | 1 | Write-protect enable, active high |
| sdaPullLow | output | 1 | Drives the data line low when 1, releases it when 0 |

## Verification
On every cycle the assertions check four things: the slave changes its data drive only while the sampled clock is low or at a start or stop; it stays silent through a write cycle; the memory is written only inside that cycle, which lasts no longer than its set length; and a write cycle never begins while full-array protection is asserted. Some behaviour shows up only in the bench's transaction scenarios: which word addresses the device byte selects, the arithmetic of page wrap and byte replacement, rollover and current-address continuation on reads, polling across the busy interval, and discarding a write on a repeated start.

// File: rtl/e2w_pkg.sv
package e2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic takeDev;
    logic takeWord;
    logic stage;
    logic loadTx;
    logic shiftTx;
    logic dropPage;
    logic commit;
  } ctlStrobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/e2w_sampler.sv
module e2w_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  // idle bus level is high on both lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/e2w_datapath.sv
module e2w_datapath
  import e2w_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 600,
  parameter bit PROT_FULL    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strb,
  input  logic       rxBit,
  input  logic       wpIn,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       busy,
  output logic       memWe
);
  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int PW      = $clog2(PAGE_BYTES);
  localparam int PAGES_W = ADDR_W - PW;
  localparam int CW      = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            mem [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVal;
  logic [PAGES_W-1:0]    pageBase;
  logic [ADDR_W-1:0]     addr;
  logic [2:0]            devHi;
  logic [7:0]            rxShift;
  logic [7:0]            txShift;
  logic [CW-1:0]         wcnt;
  logic [PW-1:0]         slot;
  logic [ADDR_W-1:0]     wordAddr;
  logic [ADDR_W-1:0]     wrAddr;
  logic                  protHit;
  logic                  inWindow;

  assign wordAddr = ADDR_W'({devHi, rxShift});
  assign slot     = wcnt[PW-1:0];
  assign wrAddr   = {pageBase, slot};
  assign inWindow = busy && (wcnt < CW'(PAGE_BYTES));
  assign memWe    = inWindow && pageVal[slot];
  assign rxByte   = rxShift;
  assign txBit    = txShift[7];

  // protected region chosen by parameter
  generate
    if (PROT_FULL) begin : g_protAll
      assign protHit = wpIn;
    end else begin : g_protUpper
      assign protHit = wpIn & pageBase[PAGES_W-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= 8'hFF;
      addr     <= '0;
      devHi    <= '0;
      pageBase <= '0;
      pageVal  <= '0;
      busy     <= 1'b0;
      wcnt     <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], rxBit};
      if (strb.takeDev) devHi <= rxShift[3:1];

      if (strb.takeWord) begin
        addr <= wordAddr;
      end else if (strb.stage) begin
        pageBuf[addr[PW-1:0]] <= rxShift;
        pageVal[addr[PW-1:0]] <= 1'b1;
        pageBase              <= addr[ADDR_W-1:PW];
        addr[PW-1:0]          <= addr[PW-1:0] + 1'b1;
      end else if (strb.loadTx) begin
        txShift <= mem[addr];
        addr    <= addr + 1'b1;
      end else if (strb.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end

      // self-timed write cycle: drains the page buffer in its first slots
      if (busy) begin
        if (wcnt == CW'(WRITE_CYCLES - 1)) begin
          busy    <= 1'b0;
          wcnt    <= '0;
          pageVal <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end else if (strb.commit) begin
        if (|pageVal && !protHit) begin
          busy <= 1'b1;
          wcnt <= '0;
        end else begin
          pageVal <= '0;
        end
      end else if (strb.dropPage) begin
        pageVal <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (memWe) mem[wrAddr] <= pageBuf[slot];
  end
endmodule

// File: rtl/e2w_control.sv
module e2w_control
  import e2w_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic [3:0] devType,
  input  logic       rwBit,
  input  logic       busy,
  input  logic       txBit,
  output ctlStrobe_t strb,
  output logic       sdaPullLow
);
  busState_t  state, stateNx;
  logic [3:0] bitCnt, bitCntNx;
  logic       ackDrv, ackDrvNx;
  logic       txDrv, txDrvNx;
  logic       rdReq, rdReqNx;
  logic       mAck, mAckNx;

  always_comb begin
    stateNx  = state;
    bitCntNx = bitCnt;
    ackDrvNx = ackDrv;
    txDrvNx  = txDrv;
    rdReqNx  = rdReq;
    mAckNx   = mAck;
    strb     = '0;
    if (startDet) begin
      stateNx       = ST_DEV;
      bitCntNx      = '0;
      ackDrvNx      = 1'b0;
      txDrvNx       = 1'b0;
      strb.dropPage = 1'b1;
    end else if (stopDet) begin
      stateNx     = ST_IDLE;
      bitCntNx    = '0;
      ackDrvNx    = 1'b0;
      txDrvNx     = 1'b0;
      strb.commit = 1'b1;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (sclRise) begin
            if (bitCnt < 4'd8) strb.shiftIn = 1'b1;
            bitCntNx = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_DEV) begin
              if (devType == DEV_TYPE && !busy) begin
                ackDrvNx     = 1'b1;
                strb.takeDev = 1'b1;
                rdReqNx      = rwBit;
              end else begin
                stateNx = ST_WAIT;
              end
            end else if (state == ST_WORD) begin
              ackDrvNx      = 1'b1;
              strb.takeWord = 1'b1;
            end else begin
              ackDrvNx   = 1'b1;
              strb.stage = 1'b1;
            end
          end else if (sclFall && bitCnt == 4'd9) begin
            ackDrvNx = 1'b0;
            bitCntNx = '0;
            if (state == ST_DEV) begin
              if (rdReq) begin
                stateNx     = ST_RDATA;
                strb.loadTx = 1'b1;
                txDrvNx     = 1'b1;
              end else begin
                stateNx = ST_WORD;
              end
            end else if (state == ST_WORD) begin
              stateNx = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCntNx = bitCnt + 1'b1;
            if (bitCnt == 4'd8) mAckNx = ~sdaS;
          end else if (sclFall) begin
            if (bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
              strb.shiftTx = 1'b1;
            end else if (bitCnt == 4'd8) begin
              txDrvNx = 1'b0;
            end else if (bitCnt == 4'd9) begin
              bitCntNx = '0;
              if (mAck) begin
                strb.loadTx = 1'b1;
                txDrvNx     = 1'b1;
              end else begin
                stateNx = ST_WAIT;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackDrv <= 1'b0;
      txDrv  <= 1'b0;
      rdReq  <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateNx;
      bitCnt <= bitCntNx;
      ackDrv <= ackDrvNx;
      txDrv  <= txDrvNx;
      rdReq  <= rdReqNx;
      mAck   <= mAckNx;
    end
  end

  assign sdaPullLow = ackDrv | (txDrv & ~txBit);
endmodule

// File: rtl/e2w_slave.sv
module e2w_slave
  import e2w_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 600,
  parameter bit PROT_FULL    = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaPullLow
);
  logic       sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic       busy, memWe, txBit;
  logic [7:0] rxByte;
  ctlStrobe_t strb;

  e2w_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  e2w_control u_control (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS),
    .devType(rxByte[7:4]), .rwBit(rxByte[0]), .busy(busy), .txBit(txBit),
    .strb(strb), .sdaPullLow(sdaPullLow)
  );

  e2w_datapath #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES), .PROT_FULL(PROT_FULL)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(sdaS), .wpIn(wpIn),
    .rxByte(rxByte), .txBit(txBit), .busy(busy), .memWe(memWe)
  );
endmodule

// File: rtl/e2w_checker.sv
module e2w_checker #(
  parameter int WRITE_CYCLES = 600,
  parameter bit PROT_FULL    = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic sclS,
  input logic startDet,
  input logic stopDet,
  input logic sdaPullLow,
  input logic busy,
  input logic memWe,
  input logic wpIn
);
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> (!$past(sclS) || $past(startDet) || $past(stopDet))); // R5
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaPullLow); // R2
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaPullLow); // R8
  AST_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R12
  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= WRITE_CYCLES); // R6
  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (PROT_FULL && $rose(busy)) |-> !$past(wpIn)); // R9
endmodule

bind e2w_slave e2w_checker #(.WRITE_CYCLES(WRITE_CYCLES), .PROT_FULL(PROT_FULL)) u_checker (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startDet(startDet), .stopDet(stopDet),
  .sdaPullLow(sdaPullLow), .busy(busy), .memWe(memWe), .wpIn(wpIn)
);

// File: tb/tb_e2w_slave.sv
module tb_e2w_slave;
  localparam int WC = 600;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic sdaPullLow;
  logic sdaBus;
  int   nChecks = 0;
  int   nFail = 0;
  bit   moved = 1'b0;
  logic [7:0] wbuf [0:31];
  logic [7:0] rbuf [0:31];

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  e2w_slave #(.MEM_BYTES(1024), .PAGE_BYTES(16), .WRITE_CYCLES(WC), .PROT_FULL(1'b1)) dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .wpIn(wp), .sdaPullLow(sdaPullLow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devB(input logic [9:0] a, input logic rd);
    return {4'b1010, 1'b0, a[9:8], rd};
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); scl = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ();
    acked = ~sdaBus;
    waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    logic first;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ();
      first = sdaBus; b[i] = sdaBus;
      waitQ();
      if (sdaBus !== first) moved = 1'b1;
      scl = 1'b0; waitQ();
    end
    sdaM = ~giveAck; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic writeSeq(input logic [9:0] a, input int n, input string tag);
    logic ak;
    busStart();
    sendByte(devB(a, 1'b0), ak); chk(ak, tag, ak, 1);
    sendByte(a[7:0], ak); chk(ak, tag, ak, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], ak); chk(ak, tag, ak, 1);
    end
    busStop();
  endtask

  task automatic readSeq(input logic [9:0] a, input int n, input bit setAddr, input string tag);
    logic ak;
    busStart();
    if (setAddr) begin
      sendByte(devB(a, 1'b0), ak); chk(ak, tag, ak, 1);
      sendByte(a[7:0], ak); chk(ak, tag, ak, 1);
      busStart();
    end
    sendByte(devB(a, 1'b1), ak); chk(ak, tag, ak, 1);
    for (int k = 0; k < n; k++) readByte(k != n - 1, rbuf[k]);
    busStop();
    chk(!moved, "R5 data stable while SCL high", moved, 0);
  endtask

  task automatic waitWrite();
    repeat (WC + 40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", nChecks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic ak;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdaPullLow == 1'b0, "R1 released after reset", sdaPullLow, 0);

    // R3: wrong device type, then bytes ignored until start
    busStart();
    sendByte(8'hB0, ak); chk(!ak, "R3 wrong type nacked", ak, 0);
    sendByte(8'hA0, ak); chk(!ak, "R3 ignored until start", ak, 0);
    busStop();

    // R2: start in mid-byte restarts framing
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart();
    sendByte(8'hA1, ak); chk(ak, "R2 start restarts framing", ak, 1);
    readByte(1'b0, rbuf[0]);
    busStop();
    chk(sdaPullLow == 1'b0, "R2 stop releases line", sdaPullLow, 0);

    // R6 and R8: byte write, poll while busy, ack afterwards
    wbuf[0] = 8'h3C;
    writeSeq(10'h2A5, 1, "R6 byte write ack");
    busStart();
    sendByte(devB(10'h0, 1'b0), ak); chk(!ak, "R8 nack while busy", ak, 0);
    busStop();
    waitWrite();
    busStart();
    sendByte(devB(10'h0, 1'b0), ak); chk(ak, "R8 ack after cycle", ak, 1);
    busStop();
    readSeq(10'h2A5, 1, 1'b1, "R10 random read");
    chk(rbuf[0] == 8'h3C, "R6 R10 byte readback", rbuf[0], 8'h3C);

    // R4: sweep upper word-address bits taken from device byte
    for (int h = 0; h < 4; h++) begin
      wbuf[0] = 8'(8'h10 + h * 7);
      writeSeq({h[1:0], 8'h5A}, 1, "R4 sweep write");
      waitWrite();
    end
    for (int h = 0; h < 4; h++) begin
      readSeq({h[1:0], 8'h5A}, 1, 1'b1, "R4 sweep read");
      chk(rbuf[0] == 8'(8'h10 + h * 7), "R4 upper bits select", rbuf[0], 8'h10 + h * 7);
    end

    // R7: 20 bytes from offset 12 of page 0x130 wrap inside the page
    for (int k = 0; k < 20; k++) wbuf[k] = 8'(k * 3 + 1);
    writeSeq(10'h13C, 20, "R7 page write ack");
    waitWrite();
    readSeq(10'h130, 16, 1'b1, "R11 sequential read");
    for (int o = 0; o < 16; o++)
      chk(rbuf[o] == 8'((o + 4) * 3 + 1), "R7 page wrap", rbuf[o], (o + 4) * 3 + 1);

    // R7: partial page write leaves the rest
    for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'hE0 + k);
    writeSeq(10'h135, 3, "R7 partial ack");
    waitWrite();
    readSeq(10'h130, 16, 1'b1, "R7 partial read");
    for (int o = 0; o < 16; o++) begin
      if (o >= 5 && o <= 7)
        chk(rbuf[o] == 8'(8'hE0 + o - 5), "R7 partial new", rbuf[o], 8'hE0 + o - 5);
      else
        chk(rbuf[o] == 8'((o + 4) * 3 + 1), "R7 partial kept", rbuf[o], (o + 4) * 3 + 1);
    end

    // R11: rollover 0x3FF -> 0x000 and current-address continuation
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
    writeSeq(10'h3FE, 2, "R11 setup high");
    waitWrite();
    wbuf[0] = 8'hC3; wbuf[1] = 8'hD4;
    writeSeq(10'h000, 2, "R11 setup low");
    waitWrite();
    readSeq(10'h3FE, 4, 1'b1, "R11 rollover read");
    chk(rbuf[0] == 8'hA1, "R11 rollover 3FE", rbuf[0], 8'hA1);
    chk(rbuf[1] == 8'hB2, "R11 rollover 3FF", rbuf[1], 8'hB2);
    chk(rbuf[2] == 8'hC3, "R11 rollover 000", rbuf[2], 8'hC3);
    chk(rbuf[3] == 8'hD4, "R11 rollover 001", rbuf[3], 8'hD4);
    readSeq(10'h3FE, 2, 1'b1, "R11 short read");
    readSeq(10'h000, 2, 1'b0, "R11 current read");
    chk(rbuf[0] == 8'hC3, "R11 current address", rbuf[0], 8'hC3);
    chk(rbuf[1] == 8'hD4, "R11 current next", rbuf[1], 8'hD4);

    // R9: write protect blocks commit and busy
    wp = 1'b1;
    wbuf[0] = 8'h77;
    writeSeq(10'h2A5, 1, "R9 protected write ack");
    busStart();
    sendByte(devB(10'h0, 1'b0), ak); chk(ak, "R9 no write cycle", ak, 1);
    busStop();
    readSeq(10'h2A5, 1, 1'b1, "R9 read");
    chk(rbuf[0] == 8'h3C, "R9 protected unchanged", rbuf[0], 8'h3C);
    wp = 1'b0;
    writeSeq(10'h2A5, 1, "R9 unprotected write");
    waitWrite();
    readSeq(10'h2A5, 1, 1'b1, "R9 read");
    chk(rbuf[0] == 8'h77, "R9 unprotected written", rbuf[0], 8'h77);

    // R12: repeated start before stop discards staged bytes
    busStart();
    sendByte(devB(10'h2A5, 1'b0), ak);
    sendByte(8'hA5, ak);
    sendByte(8'h99, ak);
    busStart();
    sendByte(devB(10'h0, 1'b0), ak); chk(ak, "R12 no cycle after restart", ak, 1);
    busStop();
    readSeq(10'h2A5, 1, 1'b1, "R12 read");
    chk(rbuf[0] == 8'h77, "R12 discarded on restart", rbuf[0], 8'h77);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule